// File: doc/BRIEF.md
# Serial Flash Boot Image Reader

This block is the SPI master that fetches a configuration image from a serial NOR flash when a reconfiguration is requested. A small write port, addressed by a 3-bit parameter code, holds the image start address and an enable flag. A start pulse launches one read. When the flash uses 4-byte addressing, the block first sends the enter-4-byte-address command in a chip-select frame of its own. It then opens the read frame with the fast-read opcode, the address bytes and four dummy clocks, and streams the returned bytes out over a valid/ready byte interface.

The stored start address keeps only its upper 24 bits. In 3-byte mode those 24 bits are the three address bytes. In 4-byte mode a fourth byte of 0x00 follows them. A start address of zero therefore points at the default image at offset 0. The number of bytes to fetch comes from a count input that is sampled at start. The serial clock runs at the system clock divided by a parameter, and it pauses while the consumer holds ready low.

Top module: `flash_boot_reader`

## Requirements
- R1: A write with code 3'b100 stores bits 31:8 of the data word as the start address. A write with code 3'b101 enables the reader only if the data word equals 1, and any other value disables it. Writes with any other code change nothing.
- R2: A start pulse is accepted only while the block is idle and enabled. Busy is high from the cycle after an accepted start until done. A start pulse arriving while busy, or while the block is disabled, produces no SPI activity.
- R3: The read frame begins with opcode 0x0B, followed by the address most-significant byte first. In 3-byte mode the address bytes are the stored bits 31:24, 23:16 and 15:8 (a written 0xABCDEF98 sends 0x0B, 0xAB, 0xCD, 0xEF).
- R4: In 4-byte mode the same three bytes are sent, followed by a fourth address byte of 0x00.
- R5: In 4-byte mode the read frame is preceded by a separate chip-select frame carrying only opcode 0xB7 (exactly 8 SPI clocks). Chip select stays high for at least CS_GAP system clocks between the two frames. In 3-byte mode only the read frame is sent.
- R6: Exactly 4 dummy SPI clocks follow the last address byte. Data bits are sampled from the next rising edge onward, most-significant bit first.
- R7: The SPI interface uses mode 0. SCK is low whenever chip select is high, MOSI changes only while SCK is low, and every SCK high phase and every in-byte low phase lasts CLK_DIV system clocks.
- R8: Each received byte is presented with rd_valid. rd_data is held stable until it is accepted with rd_ready. SCK stays low while a byte is waiting, so no byte is lost.
- R9: After byte_count bytes have been received, chip select rises. Once the last byte has been accepted, done pulses for one cycle and busy falls in that same cycle.
- R10: A start address of zero sends all-zero address bytes, which selects the default image at offset 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Parameter write strobe |
| cfg_code | input | 3 | Parameter code of the write |
| cfg_data | input | 32 | Parameter write data |
| addr4_mode | input | 1 | Static select: 1 = 4-byte flash addressing |
| start | input | 1 | Reconfiguration read request pulse |
| byte_count | input | CNT_W | Number of image bytes to fetch, sampled at start |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |
| rd_valid | output | 1 | Image byte available |
| rd_data | output | 8 | Image byte |
| rd_ready | input | 1 | Consumer accepts the image byte |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle pulse at the end of a read |

## Verification
Reads are run with several address patterns. The pattern 0xABCDEF98 shows whether the low byte is dropped in 3-byte mode and replaced by 0x00 in 4-byte mode. The pattern 0x01000000 separates the most-significant byte from the others. A zero address confirms that the default image is selected. The flash model answers with a position-dependent byte sequence that begins only after the expected header length, so one clock too many or too few in the dummy or address phase corrupts every data byte. Each mode is run both with ready held high and with ready stalling in a periodic pattern, which tells a correct back-pressure stall apart from a dropped or repeated byte. Disabled starts, enable values other than 1, writes with unused codes and a second start during a read check that these inputs leave the SPI pins and the done count untouched.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
  localparam logic [7:0] OP_FAST_READ   = 8'h0B;
  localparam logic [7:0] OP_ADDR4_ENTER = 8'hB7;
  localparam logic [3:0] DUMMY_BITS     = 4'd4;
  localparam logic [3:0] BYTE_BITS      = 4'd8;
  localparam logic [2:0] CODE_START_ADDR = 3'b100;
  localparam logic [2:0] CODE_ENABLE     = 3'b101;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ENTER, ST_GAP, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_END
  } seq_state_t;

  // Address byte by position: upper 24 stored bits, then a zero byte.
  function automatic logic [7:0] addr_byte(input logic [23:0] hi, input logic [1:0] idx);
    case (idx)
      2'd0:    return hi[23:16];
      2'd1:    return hi[15:8];
      2'd2:    return hi[7:0];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [1:0] last_addr_idx(input logic four);
    return four ? 2'd3 : 2'd2;
  endfunction

  function automatic logic in_frame(input seq_state_t s);
    return (s == ST_ENTER) || (s == ST_CMD) || (s == ST_ADDR) ||
           (s == ST_DUMMY) || (s == ST_DATA);
  endfunction
endpackage

// File: rtl/fbr_tick.sv
module fbr_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fbr_shifter.sv
module fbr_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [3:0] nbits,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       done,
  output logic       active
);
  logic [7:0] txsh;
  logic [3:0] bcnt;
  logic [3:0] nb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck <= 1'b0; mosi <= 1'b0; rx <= '0; done <= 1'b0; active <= 1'b0;
      txsh <= '0; bcnt <= '0; nb <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        active <= 1'b1;
        txsh   <= tx;
        mosi   <= tx[7];
        bcnt   <= '0;
        nb     <= nbits;
        sck    <= 1'b0;
      end else if (active && tick) begin
        if (!sck) begin
          sck  <= 1'b1;
          rx   <= {rx[6:0], miso};
          bcnt <= bcnt + 1'b1;
        end else begin
          sck <= 1'b0;
          if (bcnt == nb) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            txsh <= {txsh[6:0], 1'b0};
            mosi <= txsh[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/fbr_cfg.sv
module fbr_cfg
  import fbr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [2:0]  code,
  input  logic [31:0] data,
  output logic [23:0] addr_hi,
  output logic        enabled
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_hi <= '0;
      enabled <= 1'b0;
    end else if (wr) begin
      case (code)
        CODE_START_ADDR: addr_hi <= data[31:8];
        CODE_ENABLE:     enabled <= (data == 32'd1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fbr_seq.sv
module fbr_seq
  import fbr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CS_GAP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             enabled,
  input  logic [23:0]      addr_hi,
  input  logic             four_mode,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             sh_done,
  input  logic             sh_active,
  input  logic [7:0]       sh_rx,
  input  logic             rd_ready,
  output logic             sh_load,
  output logic [3:0]       sh_nbits,
  output logic [7:0]       sh_tx,
  output logic             cs_n,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             start_ok
);
  localparam int GW = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(CS_GAP - 1);

  seq_state_t       state;
  logic             issued;
  logic [1:0]       idx;
  logic [CNT_W-1:0] remain;
  logic [23:0]      f_addr;
  logic             f_four;
  logic [GW-1:0]    gap;
  logic             shifting;
  logic             data_hold;

  assign shifting  = in_frame(state);
  assign data_hold = (state == ST_DATA) && rd_valid;
  assign sh_load   = shifting && !issued && !sh_active && !data_hold;
  assign cs_n      = !in_frame(state);
  assign busy      = (state != ST_IDLE);
  assign start_ok  = start && enabled && (state == ST_IDLE);

  always_comb begin
    sh_tx    = 8'h00;
    sh_nbits = BYTE_BITS;
    case (state)
      ST_ENTER: sh_tx = OP_ADDR4_ENTER;
      ST_CMD:   sh_tx = OP_FAST_READ;
      ST_ADDR:  sh_tx = addr_byte(f_addr, idx);
      ST_DUMMY: sh_nbits = DUMMY_BITS;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; issued <= 1'b0; idx <= '0; remain <= '0;
      f_addr <= '0; f_four <= 1'b0; gap <= '0;
      rd_valid <= 1'b0; rd_data <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      if (sh_load) issued <= 1'b1;
      case (state)
        ST_IDLE: if (start_ok) begin
          f_addr <= addr_hi;
          f_four <= four_mode;
          remain <= byte_count;
          idx    <= '0;
          issued <= 1'b0;
          state  <= four_mode ? ST_ENTER : ST_CMD;
        end
        ST_ENTER: if (sh_done) begin
          issued <= 1'b0;
          gap    <= '0;
          state  <= ST_GAP;
        end
        ST_GAP: begin
          if (gap == GAP_LAST) state <= ST_CMD;
          else                 gap <= gap + 1'b1;
        end
        ST_CMD: if (sh_done) begin
          issued <= 1'b0;
          idx    <= '0;
          state  <= ST_ADDR;
        end
        ST_ADDR: if (sh_done) begin
          issued <= 1'b0;
          if (idx == last_addr_idx(f_four)) state <= ST_DUMMY;
          else                               idx <= idx + 1'b1;
        end
        ST_DUMMY: if (sh_done) begin
          issued <= 1'b0;
          state  <= (remain == '0) ? ST_END : ST_DATA;
        end
        ST_DATA: if (sh_done) begin
          issued   <= 1'b0;
          rd_data  <= sh_rx;
          rd_valid <= 1'b1;
          remain   <= remain - 1'b1;
          if (remain == CNT_W'(1)) state <= ST_END;
        end
        ST_END: if (!rd_valid) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_boot_reader.sv
module flash_boot_reader #(
  parameter int CLK_DIV = 2,
  parameter int CS_GAP  = 2,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [2:0]       cfg_code,
  input  logic [31:0]      cfg_data,
  input  logic             addr4_mode,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  output logic             spi_sck,
  output logic             spi_cs_n,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  input  logic             rd_ready,
  output logic             busy,
  output logic             done
);
  logic [23:0] addr_hi;
  logic        enabled;
  logic        start_accept;
  logic        sh_load, sh_done, sh_active, tick;
  logic [3:0]  sh_nbits;
  logic [7:0]  sh_tx, sh_rx;

  fbr_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .code(cfg_code), .data(cfg_data),
    .addr_hi(addr_hi), .enabled(enabled)
  );

  fbr_seq #(.CNT_W(CNT_W), .CS_GAP(CS_GAP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .enabled(enabled),
    .addr_hi(addr_hi), .four_mode(addr4_mode), .byte_count(byte_count),
    .sh_done(sh_done), .sh_active(sh_active), .sh_rx(sh_rx), .rd_ready(rd_ready),
    .sh_load(sh_load), .sh_nbits(sh_nbits), .sh_tx(sh_tx), .cs_n(spi_cs_n),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
    .start_ok(start_accept)
  );

  fbr_tick #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(sh_active), .tick(tick)
  );

  fbr_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(sh_load), .nbits(sh_nbits),
    .tx(sh_tx), .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .rx(sh_rx),
    .done(sh_done), .active(sh_active)
  );
endmodule

// File: rtl/fbr_checker.sv
module fbr_checker #(
  parameter int CS_GAP = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       spi_mosi,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       busy,
  input logic       done,
  input logic       start_accept
);
  int hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hi_cnt <= CS_GAP;
    else if (!spi_cs_n)      hi_cnt <= 0;
    else if (hi_cnt < CS_GAP) hi_cnt <= hi_cnt + 1;
  end

  p_sck_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);
  p_mosi_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sck |-> $stable(spi_mosi));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !spi_sck);
  p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> busy);
  p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_cnt >= CS_GAP));
endmodule

bind flash_boot_reader fbr_checker #(.CS_GAP(CS_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
  .spi_mosi(spi_mosi), .rd_valid(rd_valid), .rd_ready(rd_ready),
  .rd_data(rd_data), .busy(busy), .done(done), .start_accept(start_accept)
);

// File: tb/tb_flash_boot_reader.sv
`timescale 1ns/1ps
module tb_flash_boot_reader;
  localparam int CLK_DIV = 2;
  localparam int CS_GAP  = 2;
  localparam int CNT_W   = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0, addr4_mode = 1'b0, start = 1'b0, rd_ready = 1'b1;
  logic [2:0] cfg_code = '0;
  logic [31:0] cfg_data = '0;
  logic [CNT_W-1:0] byte_count = '0;
  logic spi_sck, spi_cs_n, spi_mosi, spi_miso = 1'b0;
  logic rd_valid, busy, done;
  logic [7:0] rd_data;

  flash_boot_reader #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_code(cfg_code), .cfg_data(cfg_data),
    .addr4_mode(addr4_mode), .start(start), .byte_count(byte_count),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready), .busy(busy), .done(done)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit fin = 0;

  // ---- flash model ----
  int nframes = 0, bitcnt = 0, gapcnt = 1000, last_edge = 0;
  logic pcs = 1'b1, psck = 1'b0;
  logic [7:0] shr = '0;
  logic [7:0] fbytes [16][8];
  int frises [16];
  int fgap [16];
  bit have_fall = 0;
  int hi_min = 1000000, hi_max = 0, lo_min = 1000000;
  int pat_seed = 0, hdr_len = 44;
  bit stall = 0;

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((k * 37 + seed) & 255);
  endfunction

  function automatic logic miso_bit(input int n);
    int d;
    logic [7:0] b;
    d = n - hdr_len;
    if (d < 0) return 1'b0;
    b = pat(pat_seed, d / 8);
    return b[7 - (d % 8)];
  endfunction

  always @(negedge clk) begin
    if (spi_cs_n === 1'b1) begin
      if (!pcs) nframes++;
      gapcnt++;
    end else if (spi_cs_n === 1'b0) begin
      if (pcs) begin
        if (nframes < 16) begin fgap[nframes] = gapcnt; frises[nframes] = 0; end
        bitcnt = 0; shr = '0; have_fall = 0;
        spi_miso = miso_bit(0);
      end
      gapcnt = 0;
      if (spi_sck && !psck) begin
        shr = {shr[6:0], spi_mosi};
        bitcnt++;
        if (nframes < 16) begin
          frises[nframes]++;
          if ((bitcnt % 8) == 0 && (bitcnt / 8) <= 8) fbytes[nframes][bitcnt/8 - 1] = shr;
        end
        if (have_fall && (cyc - last_edge) < lo_min) lo_min = cyc - last_edge;
        last_edge = cyc;
      end
      if (!spi_sck && psck) begin
        if ((cyc - last_edge) < hi_min) hi_min = cyc - last_edge;
        if ((cyc - last_edge) > hi_max) hi_max = cyc - last_edge;
        last_edge = cyc;
        have_fall = 1;
        spi_miso = miso_bit(bitcnt);
      end
    end
    pcs = spi_cs_n;
    psck = spi_sck;
  end

  // ---- consumer ----
  logic [7:0] rx_log [64];
  int rx_n = 0, done_cnt = 0;
  always @(negedge clk) begin
    rd_ready = stall ? ((cyc % 5) >= 3) : 1'b1;
    if (rd_valid && rd_ready && rx_n < 64) begin rx_log[rx_n] = rd_data; rx_n++; end
    if (done) done_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] code, input logic [31:0] data);
    @(negedge clk); cfg_wr = 1'b1; cfg_code = code; cfg_data = data;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic t_reset();
    chk(spi_cs_n == 1'b1, "R7", "cs_n after reset", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R7", "sck after reset", spi_sck, 0);
    chk(busy == 1'b0, "R2", "busy after reset", busy, 0);
    chk(rd_valid == 1'b0 && done == 1'b0, "R9", "valid/done after reset", {rd_valid, done}, 0);
  endtask

  task automatic t_disabled(input logic [31:0] en_val);
    int nf0, d0;
    cfg_write(3'b101, en_val);
    nf0 = nframes; d0 = done_cnt;
    pulse_start();
    chk(busy == 1'b0, "R2", "busy on disabled start", busy, 0);
    repeat (60) @(negedge clk);
    chk(nframes == nf0 && spi_cs_n == 1'b1, "R1", "frames with enable value not 1",
        nframes - nf0, 0);
    chk(done_cnt == d0, "R2", "done on disabled start", done_cnt - d0, 0);
  endtask

  task automatic t_read(input bit four, input logic [31:0] addr, input int n,
                        input bit stl, input int seed, input bit restart);
    int nf0, rx0, d0, t, len, fr, bad, firstbad_a, firstbad_e;
    string areq;
    logic [7:0] exp_b;
    cfg_write(3'b100, addr);
    cfg_write(3'b110, ~addr);          // unused code: must be ignored (R1)
    cfg_write(3'b011, 32'h5A5A_5A00);  // unused code: must be ignored (R1)
    len = four ? 4 : 3;
    addr4_mode = four; byte_count = CNT_W'(n); stall = stl;
    pat_seed = seed; hdr_len = 8 + 8 * len + 4;
    nf0 = nframes; rx0 = rx_n; d0 = done_cnt;
    pulse_start();
    chk(busy == 1'b1, "R2", "busy after accepted start", busy, 1);
    if (restart) begin
      repeat (40) @(negedge clk);
      chk(busy == 1'b1, "R2", "still busy before second start", busy, 1);
      pulse_start();
    end
    t = 0;
    while (done_cnt == d0 && t < 20000) begin @(negedge clk); t++; end
    chk(done_cnt > d0, "R9", "done seen", done_cnt - d0, 1);
    chk(busy == 1'b0 && spi_cs_n == 1'b1, "R9", "idle after done", {busy, spi_cs_n}, 1);
    repeat (120) @(negedge clk);
    chk(done_cnt - d0 == 1, "R9", "single done pulse", done_cnt - d0, 1);
    chk(nframes - nf0 == (four ? 2 : 1), "R5", "frame count", nframes - nf0, four ? 2 : 1);
    if (restart)
      chk(nframes - nf0 == 1 && done_cnt - d0 == 1, "R2", "second start ignored",
          nframes - nf0, 1);
    fr = nf0;
    if (four) begin
      chk(fbytes[nf0][0] == 8'hB7, "R5", "enter-4-byte opcode", fbytes[nf0][0], 8'hB7);
      chk(frises[nf0] == 8, "R5", "enter frame clocks", frises[nf0], 8);
      chk(fgap[nf0 + 1] >= CS_GAP, "R5", "cs gap cycles", fgap[nf0 + 1], CS_GAP);
      fr = nf0 + 1;
    end
    chk(fbytes[fr][0] == 8'h0B, "R3", "read opcode", fbytes[fr][0], 8'h0B);
    areq = (addr == 0) ? "R10" : (four ? "R4" : "R3");
    for (int i = 0; i < len; i++) begin
      exp_b = (i < 3) ? 8'((addr >> (24 - 8 * i)) & 32'hFF) : 8'h00;
      chk(fbytes[fr][i + 1] == exp_b, areq, $sformatf("address byte %0d", i),
          fbytes[fr][i + 1], exp_b);
    end
    chk(frises[fr] == hdr_len + 8 * n, "R6", "read frame clocks", frises[fr], hdr_len + 8 * n);
    chk(rx_n - rx0 == n, "R8", "bytes delivered", rx_n - rx0, n);
    bad = 0; firstbad_a = 0; firstbad_e = 0;
    for (int k = 0; k < n; k++) begin
      if (rx_log[rx0 + k] != pat(seed, k)) begin
        if (bad == 0) begin firstbad_a = rx_log[rx0 + k]; firstbad_e = pat(seed, k); end
        bad++;
      end
    end
    chk(bad == 0, stl ? "R8" : "R6", "data bytes after dummy clocks", firstbad_a, firstbad_e);
    stall = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled(32'd0);
    t_disabled(32'd3);
    cfg_write(3'b101, 32'd1);
    t_read(1'b0, 32'hABCD_EF98, 3, 1'b0, 11, 1'b0);
    t_read(1'b1, 32'h0100_0000, 5, 1'b1, 90, 1'b0);
    t_read(1'b1, 32'hABCD_EF98, 4, 1'b0, 17, 1'b0);
    t_read(1'b0, 32'h0012_3400, 6, 1'b1, 3, 1'b1);
    t_read(1'b0, 32'h0000_0000, 2, 1'b0, 200, 1'b0);
    t_read(1'b1, 32'h0000_0000, 2, 1'b1, 77, 1'b0);
    t_disabled(32'd0);
    chk(hi_min == CLK_DIV && hi_max == CLK_DIV, "R7", "sck high time", hi_max, CLK_DIV);
    chk(lo_min == CLK_DIV, "R7", "sck in-byte low time", lo_min, CLK_DIV);
    fin = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !fin) begin
      fin = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule